// File: doc/BRIEF.md
# Cache-Control Operation Sequencer

This block carries out one cache-management operation at a time against a single data-cache line. It takes an operation code, along with the line's current coherence state. From these it works out the bus transaction the operation needs and the state the line must end in. It then runs a request/grant exchange with the bus and, once the bus has taken the request, presents the new state with a write strobe and a completion pulse.

Operations that need no bus traffic finish one cycle after they are accepted. The barrier operation first holds back until the memory queue reports empty. A line reload caused by a touch operation takes its final state from the shared-response signal returned with the grant.

Top module: `cache_op_seq`

## Requirements
- R1: After reset `busy`, `bus_req`, `done` and `line_wr` are 0 and `bus_cmd` is 0.
- R2: Operation code 3 (data invalidate) issues bus command 4 (kill) and writes state 00 (Invalid) from any state. Line states are encoded I=00, S=01, E=10, M=11.
- R3: Operation code 4 (flush) issues command 7 (write-with-kill) on a line in state 11. On any other state it issues command 5 (flush). In both cases it writes state 00.
- R4: Operation code 5 (clean) on state 11 issues command 7 and writes state 10. On any other state it issues command 6 (clean) and does not write.
- R5: Operation code 6 (zero-line) on state 00 or 01 issues command 4 and writes 11. On state 10 or 11 it issues no command and writes 11, with `done` high in the cycle after acceptance.
- R6: Operation codes 7 and 8 (touch for load / for store) on state 00 issue command 8 (read). They write 01 if `bus_shared` is high on the granting cycle and 10 otherwise. On any other state they issue nothing, do not write, and complete in the cycle after acceptance.
- R7: Operation code 0 (barrier) raises no request while `mq_empty` is low, then issues command 1. Code 1 (fence) issues command 2. Code 9 (translation sync) issues command 9. None of these three writes. Code 2 (instruction invalidate) issues command 3 and writes 00.
- R8: While `bus_req` is high without `bus_grant`, the request and `bus_cmd` hold steady. In the cycle after a cycle with both high, `done` (with `line_wr` where a write applies) is high and `bus_req` is low.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle. An `op_valid` seen while `busy` is ignored and produces no extra completion.
- R10: `bus_cmd` is 0 whenever `bus_req` is low. `line_wr` is only ever high together with `done`.
- R11: Operation codes 10 to 15 complete in the cycle after acceptance with no request and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| line_state | input | 2 | Current line state, sampled with the strobe |
| mq_empty | input | 1 | Memory queue is empty |
| bus_grant | input | 1 | Bus accepts the pending request |
| bus_shared | input | 1 | Shared response returned with a read grant |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 4 | Bus command, 0 when idle |
| busy | output | 1 | Operation in progress |
| line_wr | output | 1 | Line state write strobe |
| line_next | output | 2 | New line state |
| done | output | 1 | Completion pulse |

## Verification
The assertions check the handshake on every cycle: the request holds with a stable command until the grant, completion follows the grant in the very next cycle, the command is zero when no request is raised, no request appears before the memory queue drains, and writes only occur with completion. The mapping from operation and line state to bus command and final state, the selection of the reload state from the shared response, and the rejection of strobes that arrive while busy can only be shown by the bench's scenarios, which compare each completion against an independently computed expectation.

// File: rtl/cop_pkg.sv
package cop_pkg;

  localparam int OP_W  = 4;
  localparam int CMD_W = 4;
  localparam int ST_W  = 2;

  localparam logic [ST_W-1:0] LS_I = 2'b00;
  localparam logic [ST_W-1:0] LS_S = 2'b01;
  localparam logic [ST_W-1:0] LS_E = 2'b10;
  localparam logic [ST_W-1:0] LS_M = 2'b11;

  localparam logic [OP_W-1:0] OP_BARRIER = 4'd0;
  localparam logic [OP_W-1:0] OP_FENCE   = 4'd1;
  localparam logic [OP_W-1:0] OP_ICINV   = 4'd2;
  localparam logic [OP_W-1:0] OP_DCINV   = 4'd3;
  localparam logic [OP_W-1:0] OP_FLUSH   = 4'd4;
  localparam logic [OP_W-1:0] OP_CLEAN   = 4'd5;
  localparam logic [OP_W-1:0] OP_ZERO    = 4'd6;
  localparam logic [OP_W-1:0] OP_TCH_LD  = 4'd7;
  localparam logic [OP_W-1:0] OP_TCH_ST  = 4'd8;
  localparam logic [OP_W-1:0] OP_TSYNC   = 4'd9;

  localparam logic [CMD_W-1:0] BC_NONE    = 4'd0;
  localparam logic [CMD_W-1:0] BC_SYNC    = 4'd1;
  localparam logic [CMD_W-1:0] BC_ORDER   = 4'd2;
  localparam logic [CMD_W-1:0] BC_ICINV   = 4'd3;
  localparam logic [CMD_W-1:0] BC_KILL    = 4'd4;
  localparam logic [CMD_W-1:0] BC_FLUSH   = 4'd5;
  localparam logic [CMD_W-1:0] BC_CLEAN   = 4'd6;
  localparam logic [CMD_W-1:0] BC_WR_KILL = 4'd7;
  localparam logic [CMD_W-1:0] BC_READ    = 4'd8;
  localparam logic [CMD_W-1:0] BC_TSYNC   = 4'd9;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic             wr;
    logic [ST_W-1:0]  nxt;
    logic             reload;
    logic             drain;
  } op_plan_t;

  function automatic op_plan_t plan_op(input logic [OP_W-1:0] op,
                                       input logic [ST_W-1:0] st);
    op_plan_t p;
    logic dirty;
    logic absent;
    dirty  = (st == LS_M);
    absent = (st == LS_I);
    p = '{cmd: BC_NONE, wr: 1'b0, nxt: st, reload: 1'b0, drain: 1'b0};
    case (op)
      OP_BARRIER: begin p.cmd = BC_SYNC; p.drain = 1'b1; end
      OP_FENCE:   p.cmd = BC_ORDER;
      OP_TSYNC:   p.cmd = BC_TSYNC;
      OP_ICINV:   begin p.cmd = BC_ICINV; p.wr = 1'b1; p.nxt = LS_I; end
      OP_DCINV:   begin p.cmd = BC_KILL;  p.wr = 1'b1; p.nxt = LS_I; end
      OP_FLUSH: begin
        p.cmd = dirty ? BC_WR_KILL : BC_FLUSH;
        p.wr  = 1'b1;
        p.nxt = LS_I;
      end
      OP_CLEAN: begin
        p.cmd = dirty ? BC_WR_KILL : BC_CLEAN;
        p.wr  = dirty;
        p.nxt = dirty ? LS_E : st;
      end
      OP_ZERO: begin
        p.cmd = st[1] ? BC_NONE : BC_KILL;
        p.wr  = 1'b1;
        p.nxt = LS_M;
      end
      OP_TCH_LD, OP_TCH_ST: begin
        if (absent) begin
          p.cmd    = BC_READ;
          p.wr     = 1'b1;
          p.reload = 1'b1;
        end
      end
      default: ;
    endcase
    return p;
  endfunction

  function automatic logic [ST_W-1:0] reload_state(input logic shared);
    return shared ? LS_S : LS_E;
  endfunction

endpackage

// File: rtl/cop_decode.sv
module cop_decode
  import cop_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  input  logic [ST_W-1:0] line_state,
  output op_plan_t        plan
);
  always_comb plan = plan_op(op_code, line_state);
endmodule

// File: rtl/cop_seq.sv
module cop_seq
  import cop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  op_plan_t         plan,
  input  logic             mq_empty,
  input  logic             bus_grant,
  input  logic             bus_shared,
  output logic             bus_req,
  output logic [CMD_W-1:0] bus_cmd,
  output logic             busy,
  output logic             line_wr,
  output logic [ST_W-1:0]  line_next,
  output logic             done,
  output logic             accept,
  output logic             grant_edge
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_DRAIN, SQ_REQ, SQ_FIN} seq_st_e;

  seq_st_e          sq_q;
  logic [CMD_W-1:0] cmd_q;
  logic             wr_q;
  logic             reload_q;
  logic [ST_W-1:0]  nxt_q;

  assign accept     = op_valid && (sq_q == SQ_IDLE);
  assign grant_edge = (sq_q == SQ_REQ) && bus_grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_q     <= SQ_IDLE;
      cmd_q    <= BC_NONE;
      wr_q     <= 1'b0;
      reload_q <= 1'b0;
      nxt_q    <= LS_I;
    end else begin
      case (sq_q)
        SQ_IDLE: if (accept) begin
          cmd_q    <= plan.cmd;
          wr_q     <= plan.wr;
          reload_q <= plan.reload;
          nxt_q    <= plan.nxt;
          if (plan.drain)                sq_q <= SQ_DRAIN;
          else if (plan.cmd != BC_NONE)  sq_q <= SQ_REQ;
          else                           sq_q <= SQ_FIN;
        end
        SQ_DRAIN: if (mq_empty) sq_q <= SQ_REQ;
        SQ_REQ: if (bus_grant) begin
          sq_q <= SQ_FIN;
          if (reload_q) nxt_q <= reload_state(bus_shared);
        end
        default: sq_q <= SQ_IDLE;
      endcase
    end
  end

  assign bus_req   = (sq_q == SQ_REQ);
  assign bus_cmd   = bus_req ? cmd_q : BC_NONE;
  assign busy      = (sq_q != SQ_IDLE);
  assign done      = (sq_q == SQ_FIN);
  assign line_wr   = done && wr_q;
  assign line_next = nxt_q;
endmodule

// File: rtl/cache_op_seq.sv
module cache_op_seq
  import cop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_code,
  input  logic [ST_W-1:0]  line_state,
  input  logic             mq_empty,
  input  logic             bus_grant,
  input  logic             bus_shared,
  output logic             bus_req,
  output logic [CMD_W-1:0] bus_cmd,
  output logic             busy,
  output logic             line_wr,
  output logic [ST_W-1:0]  line_next,
  output logic             done
);
  op_plan_t plan;
  logic     accept;
  logic     grant_edge;

  cop_decode u_dec (
    .op_code    (op_code),
    .line_state (line_state),
    .plan       (plan)
  );

  cop_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .plan       (plan),
    .mq_empty   (mq_empty),
    .bus_grant  (bus_grant),
    .bus_shared (bus_shared),
    .bus_req    (bus_req),
    .bus_cmd    (bus_cmd),
    .busy       (busy),
    .line_wr    (line_wr),
    .line_next  (line_next),
    .done       (done),
    .accept     (accept),
    .grant_edge (grant_edge)
  );
endmodule

// File: rtl/cop_checker.sv
module cop_checker
  import cop_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_grant,
  input logic [CMD_W-1:0] bus_cmd,
  input logic             busy,
  input logic             done,
  input logic             line_wr,
  input logic             mq_empty,
  input logic             accept,
  input logic             grant_edge
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_grant) |=> (bus_req && $stable(bus_cmd))); // R8

  AST_GRANT_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_edge |=> (done && !bus_req)); // R8

  AST_CMD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (bus_cmd == BC_NONE)); // R10

  AST_WR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    line_wr |-> done); // R10

  AST_SYNC_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_req) && bus_cmd == BC_SYNC) |-> $past(mq_empty)); // R7

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R9

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || bus_req) |-> busy); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

bind cache_op_seq cop_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_grant  (bus_grant),
  .bus_cmd    (bus_cmd),
  .busy       (busy),
  .done       (done),
  .line_wr    (line_wr),
  .mq_empty   (mq_empty),
  .accept     (accept),
  .grant_edge (grant_edge)
);

// File: tb/tb_cache_op_seq.sv
`timescale 1ns/1ps
module tb_cache_op_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [1:0] line_state = 2'b00;
  logic       mq_empty = 1'b1;
  logic       bus_grant = 1'b0;
  logic       bus_shared = 1'b0;
  logic       bus_req;
  logic [3:0] bus_cmd;
  logic       busy;
  logic       line_wr;
  logic [1:0] line_next;
  logic       done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cache_op_seq dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .line_state(line_state), .mq_empty(mq_empty), .bus_grant(bus_grant),
    .bus_shared(bus_shared), .bus_req(bus_req), .bus_cmd(bus_cmd),
    .busy(busy), .line_wr(line_wr), .line_next(line_next), .done(done)
  );

  typedef struct {
    logic [3:0] cmd;
    logic       wr;
    logic [1:0] nxt;
    string      tag;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Independent expectation: what the bus sees and where the line lands.
  function automatic exp_t model(input int op, input logic [1:0] st, input logic sh);
    exp_t e;
    bit mod, inv, shr;
    mod = (st == 2'b11); inv = (st == 2'b00); shr = (st == 2'b01);
    e.cmd = 4'd0; e.wr = 1'b0; e.nxt = st; e.tag = "R11";
    if (op == 0)      begin e.cmd = 4'd1; e.tag = "R7"; end
    else if (op == 1) begin e.cmd = 4'd2; e.tag = "R7"; end
    else if (op == 9) begin e.cmd = 4'd9; e.tag = "R7"; end
    else if (op == 2) begin e.cmd = 4'd3; e.wr = 1; e.nxt = 2'b00; e.tag = "R7"; end
    else if (op == 3) begin e.cmd = 4'd4; e.wr = 1; e.nxt = 2'b00; e.tag = "R2"; end
    else if (op == 4) begin
      e.tag = "R3"; e.wr = 1; e.nxt = 2'b00;
      e.cmd = mod ? 4'd7 : 4'd5;
    end else if (op == 5) begin
      e.tag = "R4";
      if (mod) begin e.cmd = 4'd7; e.wr = 1; e.nxt = 2'b10; end
      else e.cmd = 4'd6;
    end else if (op == 6) begin
      e.tag = "R5"; e.wr = 1; e.nxt = 2'b11;
      e.cmd = (inv || shr) ? 4'd4 : 4'd0;
    end else if (op == 7 || op == 8) begin
      e.tag = "R6";
      if (inv) begin e.cmd = 4'd8; e.wr = 1; e.nxt = sh ? 2'b01 : 2'b10; end
    end
    return e;
  endfunction

  // Monitor: samples 2 ns after each rising edge.
  logic [3:0] seen_cmd = 4'd0;
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      if (bus_req) seen_cmd = bus_cmd;
      if (done) begin
        if (sb.size() == 0) begin
          chk(0, "R9", "unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(seen_cmd == e.cmd, e.tag, "bus command", seen_cmd, e.cmd);
          chk(line_wr == e.wr, e.tag, "write strobe", line_wr, e.wr);
          if (e.wr) chk(line_next == e.nxt, e.tag, "next state", line_next, e.nxt);
        end
        seen_cmd = 4'd0;
      end
    end
  end

  // Driver: pushes the expectation, strobes the op, serves the bus.
  task automatic run_op(input int op, input logic [1:0] st, input logic sh,
                        input int gdelay, input int qwait, input bit inject);
    exp_t e;
    int n, waited, qleft;
    e = model(op, st, sh);
    sb.push_back(e);
    @(negedge clk);
    op_valid = 1; op_code = op[3:0]; line_state = st;
    bus_shared = sh; mq_empty = (qwait == 0);
    @(negedge clk);
    op_valid = 0; line_state = ~st;
    n = 0; waited = 0; qleft = qwait;
    while (!done && n < 200) begin
      op_valid = 0;
      if (qleft > 0) begin
        chk(!bus_req, "R7", "request before queue drained", bus_req, 0);
        qleft--;
        if (qleft == 0) mq_empty = 1;
      end
      if (bus_req) begin
        if (waited >= gdelay) bus_grant = 1;
        else begin
          bus_grant = 0;
          waited++;
          if (inject && waited == 1) begin
            op_valid = 1; op_code = 4'd3; line_state = 2'b11;
          end
        end
      end
      @(negedge clk);
      n++;
    end
    bus_grant = 0; op_valid = 0; mq_empty = 1;
    if (e.cmd == 4'd0)
      chk(n == 0, e.tag, "cycles to complete without bus", n, 0);
    chk(busy, "R9", "busy during done cycle", busy, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1", "busy", busy, 0);
    chk(!bus_req && bus_cmd == 0, "R1", "bus request/cmd", {bus_req, bus_cmd}, 0);
    chk(!done && !line_wr, "R1", "done/write", {done, line_wr}, 0);

    // R2 R3 R4 R5 over every line state
    for (int op = 3; op <= 6; op++)
      for (int s = 0; s < 4; s++)
        run_op(op, s[1:0], 1'b0, s, 0, 0);

    // R6 reloads and hits
    run_op(7, 2'b00, 1'b1, 1, 0, 0);
    run_op(7, 2'b00, 1'b0, 0, 0, 0);
    run_op(8, 2'b00, 1'b1, 2, 0, 0);
    run_op(8, 2'b10, 1'b0, 0, 0, 0);
    run_op(7, 2'b11, 1'b1, 0, 0, 0);
    run_op(8, 2'b01, 1'b0, 0, 0, 0);

    // R7 barrier with and without a pending queue, fence, icinv, tsync
    run_op(0, 2'b11, 1'b0, 0, 4, 0);
    run_op(0, 2'b01, 1'b0, 1, 0, 0);
    run_op(1, 2'b10, 1'b0, 0, 0, 0);
    run_op(2, 2'b11, 1'b0, 1, 0, 0);
    run_op(9, 2'b01, 1'b0, 0, 0, 0);

    // R11 undefined codes
    run_op(12, 2'b10, 1'b0, 0, 0, 0);
    run_op(15, 2'b11, 1'b0, 0, 0, 0);

    // R8 R9: long grant wait with a strobe injected while busy
    run_op(4, 2'b11, 1'b0, 5, 0, 1);
    repeat (4) @(negedge clk);
    chk(!busy, "R9", "strobe while busy was accepted", busy, 0);
    chk(sb.size() == 0, "R9", "scoreboard left over", sb.size(), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule